// File: doc/BRIEF.md
# Single-Accumulator 16-bit Processor

This block is a small processor built around one 16-bit working register (the accumulator). It holds a 12-bit program counter, an instruction register and the accumulator. A single adder/subtractor serves two jobs: it advances the program counter while an instruction is fetched, and it combines the accumulator with operand data when an instruction executes. The processor is driven by a short multi-cycle sequencer and talks to one synchronous, word-wide memory. Read data returns in the cycle after the request.

Every instruction is one 16-bit word. The top four bits select the operation and the low twelve bits name a direct word address. Eight operations are defined: load, store, add, subtract, unconditional jump, jump-if-non-negative, jump-if-non-zero and stop. The other eight codes do nothing except move on to the next instruction. Once stopped, the processor stays quiet until it is reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset (active-low `rst_n`) is held and in the cycle it is released, the block requests a read at address 0 with `halted` low. The program counter and accumulator start at zero.
- R2: An instruction word holds the operation code in bits 15:12 and the direct operand address S in bits 11:0. The address space is 4096 words of 16 bits.
- R3: Each instruction follows a fixed timing. One fetch cycle reads at PC and sets PC to PC+1 (mod 4096). Then comes one idle decode cycle, then one execute cycle. A load, add or subtract adds one more idle write-back cycle. Fetches run at consecutive addresses unless a jump is taken.
- R4: Code 0x0 loads mem[S] into the accumulator, code 0x2 adds mem[S] and code 0x3 subtracts mem[S]. Each reads S in the execute cycle, and results wrap modulo 2^16.
- R5: Code 0x1 writes the accumulator to address S in the execute cycle, with `mem_rnw` low. The accumulator is left unchanged.
- R6: Code 0x4 sets PC to S, so the next fetch is at S.
- R7: Code 0x5 sets PC to S only when accumulator bit 15 is 0, which includes the value zero. Otherwise fetching continues in sequence.
- R8: Code 0x6 sets PC to S only when the accumulator is not zero.
- R9: Codes 0x8 to 0xF make no memory access in the execute cycle and change neither PC (beyond the fetch increment) nor the accumulator.
- R10: Code 0x7 stops the processor after its execute cycle. From then on `halted` is high and `mem_req` is low until reset, and no later instruction runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_req | output | 1 | Memory access request for this cycle |
| mem_rnw | output | 1 | 1 = read, 0 = write (valid with mem_req) |
| mem_addr | output | 12 | Word address |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
The bound checker watches several rules on every cycle. Each fetch reads at the program counter, which then steps by one. A taken jump lands on the operand address. A conditional jump whose condition fails, or a spare opcode, leaves the program counter where it is. A store leaves the accumulator intact. After a stop the processor stays halted and makes no requests. Some behaviour only the bench scenarios can show: the arithmetic results with 16-bit wrap-around, the number of loop iterations a non-zero test produces, the exact cycle pattern of each instruction, and the fact that code after a stop or behind a jump never runs. A reference model executes the same program at instruction level and predicts every bus cycle.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam logic [3:0] OPC_LOAD  = 4'h0;
  localparam logic [3:0] OPC_STORE = 4'h1;
  localparam logic [3:0] OPC_ADD   = 4'h2;
  localparam logic [3:0] OPC_SUB   = 4'h3;
  localparam logic [3:0] OPC_JUMP  = 4'h4;
  localparam logic [3:0] OPC_JPOS  = 4'h5;
  localparam logic [3:0] OPC_JNZ   = 4'h6;
  localparam logic [3:0] OPC_STOP  = 4'h7;

  typedef enum logic [2:0] {
    PH_FETCH, PH_DECODE, PH_EXEC, PH_WB, PH_HALT
  } phase_e;

  typedef enum logic [1:0] {
    ALU_PASS, ALU_ADD, ALU_SUB
  } alu_fn_e;

  // branch decision: only the three jump codes may redirect the PC
  function automatic logic jump_cond(logic [3:0] opc, logic sign, logic zero);
    case (opc)
      OPC_JUMP: jump_cond = 1'b1;
      OPC_JPOS: jump_cond = !sign;
      OPC_JNZ:  jump_cond = !zero;
      default:  jump_cond = 1'b0;
    endcase
  endfunction

  function automatic alu_fn_e wb_fn(logic [3:0] opc);
    case (opc)
      OPC_ADD: wb_fn = ALU_ADD;
      OPC_SUB: wb_fn = ALU_SUB;
      default: wb_fn = ALU_PASS;
    endcase
  endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_fn_e       fn_i,
  output logic [DW-1:0] y_o
);

  function automatic logic [DW-1:0] calc(logic [DW-1:0] a, logic [DW-1:0] b, alu_fn_e fn);
    case (fn)
      ALU_ADD: calc = a + b;
      ALU_SUB: calc = a - b;
      default: calc = b;
    endcase
  endfunction

  assign y_o = calc(a_i, b_i, fn_i);

endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pc_ce,
  input  logic          pc_from_s,
  input  logic          ir_ce,
  input  logic          acc_ce,
  input  logic [DW-1:0] alu_y,
  input  logic [DW-1:0] ir_d,
  output logic [AW-1:0] pc_q,
  output logic [DW-1:0] ir_q,
  output logic [DW-1:0] acc_q
);

  logic [AW-1:0] pc_d;

  assign pc_d = pc_from_s ? ir_q[AW-1:0] : alu_y[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      if (pc_ce)  pc_q  <= pc_d;
      if (ir_ce)  ir_q  <= ir_d;
      if (acc_ce) acc_q <= alu_y;
    end
  end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opc,
  input  logic       acc_sign,
  input  logic       acc_zero,
  output phase_e     phase_o,
  output logic       pc_ce,
  output logic       pc_from_s,
  output logic       ir_ce,
  output logic       acc_ce,
  output logic       addr_from_s,
  output logic       a_from_pc,
  output logic       b_incr,
  output alu_fn_e    alu_fn,
  output logic       req,
  output logic       rnw,
  output logic       halted,
  output logic       jump_o
);

  phase_e phase_q, phase_d;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_FETCH;
    else        phase_q <= phase_d;
  end

  always_comb begin
    phase_d     = phase_q;
    pc_ce       = 1'b0;
    pc_from_s   = 1'b0;
    ir_ce       = 1'b0;
    acc_ce      = 1'b0;
    addr_from_s = 1'b0;
    a_from_pc   = 1'b0;
    b_incr      = 1'b0;
    alu_fn      = ALU_PASS;
    req         = 1'b0;
    rnw         = 1'b1;
    case (phase_q)
      PH_FETCH: begin
        req       = 1'b1;
        a_from_pc = 1'b1;
        b_incr    = 1'b1;
        alu_fn    = ALU_ADD;
        pc_ce     = 1'b1;
        phase_d   = PH_DECODE;
      end
      PH_DECODE: begin
        ir_ce   = 1'b1;
        phase_d = PH_EXEC;
      end
      PH_EXEC: begin
        phase_d = PH_FETCH;
        case (opc)
          OPC_LOAD, OPC_ADD, OPC_SUB: begin
            req         = 1'b1;
            addr_from_s = 1'b1;
            phase_d     = PH_WB;
          end
          OPC_STORE: begin
            req         = 1'b1;
            rnw         = 1'b0;
            addr_from_s = 1'b1;
          end
          OPC_STOP: phase_d = PH_HALT;
          default: begin
            if (jump_cond(opc, acc_sign, acc_zero)) begin
              pc_ce     = 1'b1;
              pc_from_s = 1'b1;
            end
          end
        endcase
      end
      PH_WB: begin
        acc_ce  = 1'b1;
        alu_fn  = wb_fn(opc);
        phase_d = PH_FETCH;
      end
      default: phase_d = PH_HALT;
    endcase
  end

  assign phase_o = phase_q;
  assign halted  = (phase_q == PH_HALT);
  assign jump_o  = pc_ce && pc_from_s;

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req,
  output logic          mem_rnw,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted
);

  localparam int OPW = DW - AW;

  logic [AW-1:0]  pc_q;
  logic [DW-1:0]  ir_q, acc_q, alu_a, alu_b, alu_y, pc_ext, one_w;
  logic [OPW-1:0] opc;
  logic           pc_ce, pc_from_s, ir_ce, acc_ce, addr_from_s, a_from_pc, b_incr;
  logic           acc_zero, jump_ev;
  alu_fn_e        alu_fn;
  phase_e         phase;

  // named events for the checker
  logic fetch_ev, exec_ev, store_ev;

  assign opc      = ir_q[DW-1 -: OPW];
  assign acc_zero = (acc_q == '0);

  always_comb begin
    pc_ext           = '0;
    pc_ext[AW-1:0]   = pc_q;
    one_w            = '0;
    one_w[0]         = 1'b1;
  end

  assign alu_a     = a_from_pc ? pc_ext : acc_q;
  assign alu_b     = b_incr ? one_w : mem_rdata;
  assign mem_addr  = addr_from_s ? ir_q[AW-1:0] : pc_q;
  assign mem_wdata = acc_q;

  assign fetch_ev = (phase == PH_FETCH);
  assign exec_ev  = (phase == PH_EXEC);
  assign store_ev = mem_req && !mem_rnw;

  acc_cpu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .opc(opc),
    .acc_sign(acc_q[DW-1]), .acc_zero(acc_zero),
    .phase_o(phase), .pc_ce(pc_ce), .pc_from_s(pc_from_s),
    .ir_ce(ir_ce), .acc_ce(acc_ce), .addr_from_s(addr_from_s),
    .a_from_pc(a_from_pc), .b_incr(b_incr), .alu_fn(alu_fn),
    .req(mem_req), .rnw(mem_rnw), .halted(halted), .jump_o(jump_ev)
  );

  acc_cpu_alu #(.DW(DW)) u_alu (
    .a_i(alu_a), .b_i(alu_b), .fn_i(alu_fn), .y_o(alu_y)
  );

  acc_cpu_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .pc_ce(pc_ce), .pc_from_s(pc_from_s),
    .ir_ce(ir_ce), .acc_ce(acc_ce), .alu_y(alu_y), .ir_d(mem_rdata),
    .pc_q(pc_q), .ir_q(ir_q), .acc_q(acc_q)
  );

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_rnw,
  input logic [AW-1:0] mem_addr,
  input logic          halted,
  input logic [AW-1:0] pc_q,
  input logic [DW-1:0] ir_q,
  input logic [DW-1:0] acc_q,
  input logic          fetch_ev,
  input logic          exec_ev,
  input logic          jump_ev,
  input logic          store_ev
);

  logic [3:0] c_opc;
  assign c_opc = ir_q[DW-1 -: 4];

  AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ev |-> (mem_req && mem_rnw && mem_addr == pc_q)); // R3
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ev |=> (pc_q == AW'($past(pc_q) + 1'b1))); // R3
  AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    store_ev |=> $stable(acc_q)); // R5
  AST_JUMP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    jump_ev |=> (pc_q == $past(ir_q[AW-1:0]))); // R6
  AST_JGE_NEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ev && c_opc == 4'h5 && acc_q[DW-1]) |=> $stable(pc_q)); // R7
  AST_JNE_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ev && c_opc == 4'h6 && acc_q == '0) |=> $stable(pc_q)); // R8
  AST_SPARE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ev && c_opc[3]) |=> ($stable(pc_q) && $stable(acc_q))); // R9
  AST_SPARE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ev && c_opc[3]) |-> !mem_req); // R9
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req); // R10
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R10

endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_rnw(mem_rnw),
  .mem_addr(mem_addr), .halted(halted), .pc_q(pc_q), .ir_q(ir_q),
  .acc_q(acc_q), .fetch_ev(fetch_ev), .exec_ev(exec_ev),
  .jump_ev(jump_ev), .store_ev(store_ev)
);

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_rnw, halted;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  acc_cpu u0 (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_rnw(mem_rnw),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted)
  );

  // bench memory (256 words, program and data live below 0x100)
  logic [15:0] ram [256];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_rnw) mem_rdata <= ram[mem_addr[7:0]];
      else         ram[mem_addr[7:0]] <= mem_wdata;
    end
  end

  // instruction-level reference model producing expected bus cycles
  logic [15:0] mmem [256];
  logic [11:0] m_pc = '0;
  logic [15:0] m_acc = '0;
  bit          m_halt = 0;
  string       m_ftag = "R3";
  logic [30:0] expq[$];   // {halted, req, rnw, addr[11:0], wdata[15:0]}
  string       tagq[$];

  task automatic push(bit h, bit rq, bit rw, logic [11:0] a, logic [15:0] wd, string t);
    expq.push_back({h, rq, rw, a, wd});
    tagq.push_back(t);
  endtask

  task automatic model_step();
    logic [15:0] w;
    logic [11:0] s;
    if (m_halt) begin
      push(1, 0, 1, 12'h0, 16'h0, "R10");
      return;
    end
    w = mmem[m_pc[7:0]];
    s = w[11:0];
    push(0, 1, 1, m_pc, 16'h0, m_ftag);
    m_ftag = "R3";
    m_pc = m_pc + 12'd1;
    push(0, 0, 1, 12'h0, 16'h0, "R3");
    case (w[15:12])
      4'h0: begin push(0,1,1,s,0,"R4"); push(0,0,1,0,0,"R4"); m_acc = mmem[s[7:0]]; end
      4'h2: begin push(0,1,1,s,0,"R4"); push(0,0,1,0,0,"R4"); m_acc = m_acc + mmem[s[7:0]]; end
      4'h3: begin push(0,1,1,s,0,"R4"); push(0,0,1,0,0,"R4"); m_acc = m_acc - mmem[s[7:0]]; end
      4'h1: begin push(0,1,0,s,m_acc,"R5"); mmem[s[7:0]] = m_acc; end
      4'h4: begin push(0,0,1,0,0,"R6"); m_pc = s; m_ftag = "R6"; end
      4'h5: begin push(0,0,1,0,0,"R7"); if (!m_acc[15]) m_pc = s; m_ftag = "R7"; end
      4'h6: begin push(0,0,1,0,0,"R8"); if (m_acc != 0) m_pc = s; m_ftag = "R8"; end
      4'h7: begin push(0,0,1,0,0,"R10"); m_halt = 1; end
      default: begin push(0,0,1,0,0,"R9"); m_ftag = "R9"; end
    endcase
  endtask

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_cycle();
    logic [30:0] e;
    string t;
    bit ok;
    e = expq.pop_front();
    t = tagq.pop_front();
    ok = (halted == e[30]) && (mem_req == e[29]);
    if (e[29]) ok = ok && (mem_rnw == e[28]) && (mem_addr == e[27:16]);
    if (e[29] && !e[28]) ok = ok && (mem_wdata == e[15:0]);
    check(ok, t, "bus cycle {halt,req,rnw,addr,wdata}",
          {1'b0, halted, mem_req, mem_rnw, mem_addr, mem_wdata}, {1'b0, e});
  endtask

  initial begin
    int settle;
    bit done;
    for (int i = 0; i < 256; i++) ram[i] = 16'h0;
    // program (R2: opcode in [15:12], address in [11:0])
    ram[8'h00] = 16'h0040; ram[8'h01] = 16'h3041; ram[8'h02] = 16'h1042;
    ram[8'h03] = 16'h6001; ram[8'h04] = 16'h5006; ram[8'h05] = 16'h7000;
    ram[8'h06] = 16'h3041; ram[8'h07] = 16'h1043; ram[8'h08] = 16'h500B;
    ram[8'h09] = 16'h2044; ram[8'h0A] = 16'h900D; ram[8'h0B] = 16'h400D;
    ram[8'h0C] = 16'h1045; ram[8'h0D] = 16'h1046; ram[8'h0E] = 16'h2047;
    ram[8'h0F] = 16'h6000; ram[8'h10] = 16'h1048; ram[8'h11] = 16'h7000;
    ram[8'h12] = 16'h1049;
    // data
    ram[8'h40] = 16'h0005; ram[8'h41] = 16'h0001; ram[8'h42] = 16'hEEEE;
    ram[8'h44] = 16'h7FFF; ram[8'h45] = 16'h1111; ram[8'h47] = 16'h8002;
    ram[8'h48] = 16'hABCD; ram[8'h49] = 16'h5A5A;
    for (int i = 0; i < 256; i++) mmem[i] = ram[i];

    repeat (3) @(negedge clk);
    check(mem_req && mem_rnw && mem_addr == 12'h000 && !halted, "R1",
          "reset {req,rnw,halt,addr}", {17'h0, mem_req, mem_rnw, halted, mem_addr},
          {17'h0, 1'b1, 1'b1, 1'b0, 12'h000});
    @(negedge clk);
    rst_n = 1'b1;

    settle = 0;
    done = 0;
    for (int cyc = 0; cyc < 3000 && !done; cyc++) begin
      if (expq.size() == 0) model_step();
      cmp_cycle();
      if (halted) settle++;
      if (settle >= 20) done = 1;
      else @(negedge clk);
    end
    if (!done) check(0, "R10", "watchdog: no halt", {31'h0, halted}, 32'h1);

    // final memory image, expected values worked out from the requirements
    check(ram[8'h42] == 16'h0000, "R8", "loop counter stored", ram[8'h42], 16'h0000);
    check(ram[8'h43] == 16'hFFFF, "R4", "0 - 1 wraps", ram[8'h43], 16'hFFFF);
    check(ram[8'h46] == 16'h7FFE, "R7", "neg JGE falls through to ADD", ram[8'h46], 16'h7FFE);
    check(ram[8'h45] == 16'h1111, "R6", "skipped store", ram[8'h45], 16'h1111);
    check(ram[8'h48] == 16'h0000, "R5", "store of zero after add wrap", ram[8'h48], 16'h0000);
    check(ram[8'h49] == 16'h5A5A, "R10", "code after stop ran", ram[8'h49], 16'h5A5A);
    check(ram[8'h0A] == 16'h900D, "R9", "spare opcode touched memory", ram[8'h0A], 16'h900D);
    check(halted && !mem_req, "R10", "halted and quiet", {30'h0, halted, mem_req}, 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule